// File: doc/BRIEF.md
# Global Comparator Timer Unit

A system timer for register-bus access. A 64-bit up-counter runs freely while its run bit is set. Software loads it, and reads it, as two 32-bit words. One comparator channel holds a 64-bit target value. When the count equals that target, a sticky status flag is set. The flag drives an interrupt line when its enable bit is set.

For periodic events, an auto-advance mode adds a programmed 32-bit step to the target on every match. The next event therefore lands exactly one step after the previous target, whatever the latency of the software that serves it.

Every write to a register that matters is confirmed by a sticky write-status bit, which software clears by writing a one to it. Reads are registered. The returned word is the value the register held in the cycle of the request, and it stays unchanged until the next read. Software builds a consistent 64-bit count by reading the high word, then the low word, then the high word again, and retrying if the two high words differ.

Top module: `gt_unit`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped and every interrupt output is 0.
- R2: A write to offset 0x100 loads the low 32 bits of the counter and a write to 0x104 loads the high 32 bits. While control bit 8 is 0, the counter holds its value.
- R3: A write to 0x100 sets bit 0 of the counter write-status word at 0x110, and a write to 0x104 sets bit 1. Each bit stays set until a 1 is written to that bit position at 0x110.
- R4: While control bit 8 (offset 0x240) is 1, the counter increases by one every clock, with the carry passing from the low word into the high word.
- R5: A read request (rd_en) returns on rdata, one clock later with rvalid high, the value the register held in the request cycle. rdata stays unchanged until the next read.
- R6: When control bit 0 is 1 and the count equals the 64-bit target (low word 0x200, high word 0x204), status bit 0 at 0x244 is set on the next clock. If enable bit 0 at 0x248 is 1, irq[0] rises one clock after that.
- R7: Writing 1 to bit 0 of 0x244 clears the status flag, and irq[0] falls one clock later.
- R8: With enable bit 0 at 0x248 at 0, a match still sets the status flag, but irq[0] stays 0.
- R9: With control bits 0 and 1 both set, each match replaces the target with the old target plus the 32-bit step at 0x208, carried across the full 64 bits.
- R10: The write-status word at 0x24C sets bit 0, 1 or 2 after a write to 0x200, 0x204 or 0x208, and bit 16 after a write to 0x240. Each bit is sticky and is cleared by writing 1 to that bit position at 0x24C.
- R11: The control register stores only bits 8, 1 and 0, and all its other bits read 0. irq[3:1] stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | rdata holds the answer to the read of the previous cycle |
| irq | output | 4 | Compare interrupt lines; only line 0 is active |

## Verification
The hardest situation to reach from the ports is an auto-advance match where the target carries from the low word into the high word while the counter runs. Otherwise that carry only happens after four billion cycles. The stimulus stops the counter and presets it a few counts below a low-word wrap, with the target just past it and a step that crosses the wrap. It then runs the counter for a known number of clocks and stops it. The bench predicts the final target, the final count and the status flag from those clock counts alone.

// File: rtl/gt_pkg.sv
package gt_pkg;
  localparam int ADDR_W  = 12;
  localparam int DATA_W  = 32;
  localparam int NUM_IRQ = 4;

  localparam logic [ADDR_W-1:0] OFF_CNT_LO = 12'h100;
  localparam logic [ADDR_W-1:0] OFF_CNT_HI = 12'h104;
  localparam logic [ADDR_W-1:0] OFF_CNT_WS = 12'h110;
  localparam logic [ADDR_W-1:0] OFF_CMP_LO = 12'h200;
  localparam logic [ADDR_W-1:0] OFF_CMP_HI = 12'h204;
  localparam logic [ADDR_W-1:0] OFF_STEP   = 12'h208;
  localparam logic [ADDR_W-1:0] OFF_CTRL   = 12'h240;
  localparam logic [ADDR_W-1:0] OFF_STAT   = 12'h244;
  localparam logic [ADDR_W-1:0] OFF_IEN    = 12'h248;
  localparam logic [ADDR_W-1:0] OFF_GEN_WS = 12'h24C;

  localparam int CTRL_RUN_BIT  = 8;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_AUTO_BIT = 1;
  localparam int WS_CTRL_BIT   = 16;
endpackage

// File: rtl/gt_counter.sv
module gt_counter #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] cnt
);
  localparam int CW = 2 * DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_lo) begin
      cnt[DW-1:0] <= wdata;
    end else if (wr_hi) begin
      cnt[CW-1:DW] <= wdata;
    end else if (run) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R2: a stopped counter keeps its value
  p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_lo && !wr_hi) |=> $stable(cnt));

  // R4: a running counter steps by one
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (run && !wr_lo && !wr_hi) |=> (cnt - $past(cnt) == CW'(1)));
endmodule

// File: rtl/gt_wstat.sv
module gt_wstat #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr[i]) q[i] <= 1'b0;
    end

    // R3 and R10: a set bit stays set until cleared by a write of one
    p_wstat_hold_r10: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr[i]) |=> q[i]);

    // R3 and R10: a confirmed write is visible on the next cycle
    p_wstat_set_r3: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> q[i]);
  end
endmodule

// File: rtl/gt_compare.sv
module gt_compare #(
  parameter int DW = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2*DW-1:0] cnt,
  input  logic            cmp_en,
  input  logic            auto_en,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic            wr_step,
  input  logic            wr_ien,
  input  logic            wr_stat,
  input  logic [DW-1:0]   wdata,
  output logic [2*DW-1:0] cmp,
  output logic [DW-1:0]   step,
  output logic            stat,
  output logic            ien,
  output logic            irq
);
  localparam int CW = 2 * DW;

  logic hit;
  assign hit = cmp_en && (cnt == cmp);

  // target register: software loads win over the auto-advance
  always_ff @(posedge clk) begin
    if (rst) begin
      cmp <= '0;
    end else if (wr_lo) begin
      cmp[DW-1:0] <= wdata;
    end else if (wr_hi) begin
      cmp[CW-1:DW] <= wdata;
    end else if (hit && auto_en) begin
      cmp <= cmp + {{DW{1'b0}}, step};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          step <= '0;
    else if (wr_step) step <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         ien <= 1'b0;
    else if (wr_ien) ien <= wdata[0];
  end

  // a new match wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst)                      stat <= 1'b0;
    else if (hit)                 stat <= 1'b1;
    else if (wr_stat && wdata[0]) stat <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= stat && ien;
  end

  // R6: an enabled match raises the status flag
  p_match_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && cnt == cmp) |=> stat);

  // R8: a masked channel never drives its line
  p_irq_masked_r8: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq);

  // R9: auto-advance moves the target by exactly one step
  p_auto_step_r9: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && auto_en && cnt == cmp && !wr_lo && !wr_hi)
      |=> (cmp - $past(cmp) == {{DW{1'b0}}, $past(step)}));
endmodule

// File: rtl/gt_unit.sv
module gt_unit
  import gt_pkg::*;
#(
  parameter int AW   = gt_pkg::ADDR_W,
  parameter int DW   = gt_pkg::DATA_W,
  parameter int NIRQ = gt_pkg::NUM_IRQ
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid,
  output logic [NIRQ-1:0] irq
);
  localparam int CW = 2 * DW;

  logic w_cnt_lo, w_cnt_hi, w_cnt_ws, w_cmp_lo, w_cmp_hi;
  logic w_step, w_ctrl, w_stat, w_ien, w_gen_ws;

  assign w_cnt_lo = wr_en && (addr == OFF_CNT_LO);
  assign w_cnt_hi = wr_en && (addr == OFF_CNT_HI);
  assign w_cnt_ws = wr_en && (addr == OFF_CNT_WS);
  assign w_cmp_lo = wr_en && (addr == OFF_CMP_LO);
  assign w_cmp_hi = wr_en && (addr == OFF_CMP_HI);
  assign w_step   = wr_en && (addr == OFF_STEP);
  assign w_ctrl   = wr_en && (addr == OFF_CTRL);
  assign w_stat   = wr_en && (addr == OFF_STAT);
  assign w_ien    = wr_en && (addr == OFF_IEN);
  assign w_gen_ws = wr_en && (addr == OFF_GEN_WS);

  // control: only run, compare enable and auto-advance are stored
  logic ctl_run, ctl_en, ctl_auto;
  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_run  <= 1'b0;
      ctl_en   <= 1'b0;
      ctl_auto <= 1'b0;
    end else if (w_ctrl) begin
      ctl_run  <= wdata[CTRL_RUN_BIT];
      ctl_en   <= wdata[CTRL_EN_BIT];
      ctl_auto <= wdata[CTRL_AUTO_BIT];
    end
  end

  logic [CW-1:0] cnt;
  gt_counter #(.DW(DW)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .run   (ctl_run),
    .wr_lo (w_cnt_lo),
    .wr_hi (w_cnt_hi),
    .wdata (wdata),
    .cnt   (cnt)
  );

  logic [CW-1:0] cmp;
  logic [DW-1:0] step;
  logic          stat, ien, irq0;
  gt_compare #(.DW(DW)) u_cmp0 (
    .clk     (clk),
    .rst     (rst),
    .cnt     (cnt),
    .cmp_en  (ctl_en),
    .auto_en (ctl_auto),
    .wr_lo   (w_cmp_lo),
    .wr_hi   (w_cmp_hi),
    .wr_step (w_step),
    .wr_ien  (w_ien),
    .wr_stat (w_stat),
    .wdata   (wdata),
    .cmp     (cmp),
    .step    (step),
    .stat    (stat),
    .ien     (ien),
    .irq     (irq0)
  );

  // counter write confirmations: bit 0 low word, bit 1 high word
  logic [1:0] cnt_ws;
  gt_wstat #(.N(2)) u_cnt_ws (
    .clk (clk),
    .rst (rst),
    .set ({w_cnt_hi, w_cnt_lo}),
    .clr ({w_cnt_ws && wdata[1], w_cnt_ws && wdata[0]}),
    .q   (cnt_ws)
  );

  // general confirmations: target low, target high, step, control
  logic [3:0] gen_ws;
  gt_wstat #(.N(4)) u_gen_ws (
    .clk (clk),
    .rst (rst),
    .set ({w_ctrl, w_step, w_cmp_hi, w_cmp_lo}),
    .clr ({w_gen_ws && wdata[WS_CTRL_BIT], w_gen_ws && wdata[2],
           w_gen_ws && wdata[1], w_gen_ws && wdata[0]}),
    .q   (gen_ws)
  );

  logic [DW-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (addr)
      OFF_CNT_LO: rd_word = cnt[DW-1:0];
      OFF_CNT_HI: rd_word = cnt[CW-1:DW];
      OFF_CNT_WS: rd_word[1:0] = cnt_ws;
      OFF_CMP_LO: rd_word = cmp[DW-1:0];
      OFF_CMP_HI: rd_word = cmp[CW-1:DW];
      OFF_STEP:   rd_word = step;
      OFF_CTRL: begin
        rd_word[CTRL_RUN_BIT]  = ctl_run;
        rd_word[CTRL_EN_BIT]   = ctl_en;
        rd_word[CTRL_AUTO_BIT] = ctl_auto;
      end
      OFF_STAT:   rd_word[0] = stat;
      OFF_IEN:    rd_word[0] = ien;
      OFF_GEN_WS: begin
        rd_word[2:0]         = gen_ws[2:0];
        rd_word[WS_CTRL_BIT] = gen_ws[3];
      end
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) rdata <= rd_word;
    end
  end

  for (genvar ch = 0; ch < NIRQ; ch++) begin : g_irq
    if (ch == 0) begin : g_live
      assign irq[ch] = irq0;
    end else begin : g_idle
      assign irq[ch] = 1'b0;
    end
  end

  // R5: every request gets exactly one answer one cycle later
  p_rvalid_follow_r5: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid);
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/gt_unit_bench.sv
module gt_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [3:0]  irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  gt_unit u_gt_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  // monitor: pops one expected word per answered read
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      logic [31:0] e;
      string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected read answer got %h exp none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s got %h exp %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string t);
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s got %h exp %h", t, got, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog run did not finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk({28'b0, irq}, 32'h0, "R1 irq after reset");
    rd(12'h240, 32'h0, "R1 control after reset");
    rd(12'h100, 32'h0, "R1 count low after reset");
    rd(12'h244, 32'h0, "R1 status after reset");
    rd(12'h24C, 32'h0, "R1 write status after reset");

    // R11 reserved control bits
    wr(12'h240, 32'hFFFF_FEFC);
    rd(12'h240, 32'h0, "R11 reserved control bits");
    wr(12'h24C, 32'hFFFF_FFFF);

    // R2 half loads, stopped counter holds
    wr(12'h100, 32'hFFFF_FFF0);
    wr(12'h104, 32'h0000_0001);
    idle(5);
    rd(12'h100, 32'hFFFF_FFF0, "R2 count low load");
    rd(12'h104, 32'h0000_0001, "R2 count high load");
    rd(12'h100, 32'hFFFF_FFF0, "R2 stopped count holds");

    // R3 counter write status
    rd(12'h110, 32'h3, "R3 both half writes confirmed");
    wr(12'h110, 32'h1);
    rd(12'h110, 32'h2, "R3 clear low confirmation");
    wr(12'h110, 32'h2);
    rd(12'h110, 32'h0, "R3 clear high confirmation");

    // R4 run 32 clocks with carry into high word
    wr(12'h240, 32'h100);
    idle(31);
    wr(12'h240, 32'h0);
    rd(12'h100, 32'h0000_0010, "R4 count low after carry");
    rd(12'h104, 32'h0000_0002, "R4 count high after carry");

    // R5 read sampling and hold
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h240, 32'h100);
    rd(12'h100, 32'h0, "R5 read in first running cycle");
    rd(12'h100, 32'h1, "R5 read one cycle later");
    idle(3);
    chk(rdata, 32'h1, "R5 rdata held between reads");
    wr(12'h240, 32'h0);
    rd(12'h100, 32'h6, "R5 count after six clocks");

    // R6 one-shot match with interrupt
    wr(12'h100, 32'h0);
    wr(12'h200, 32'd20);
    wr(12'h204, 32'h0);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h101);
    idle(21);
    chk({31'b0, irq[0]}, 32'h0, "R6 irq before match latency");
    idle(2);
    chk({31'b0, irq[0]}, 32'h1, "R6 irq after match");
    chk({29'b0, irq[3:1]}, 32'h0, "R11 idle channels");
    rd(12'h244, 32'h1, "R6 status after match");

    // R7 clear status
    wr(12'h244, 32'h1);
    chk({31'b0, irq[0]}, 32'h1, "R7 irq one cycle after clear");
    idle(1);
    chk({31'b0, irq[0]}, 32'h0, "R7 irq dropped");
    rd(12'h244, 32'h0, "R7 status cleared");

    // R8 masked interrupt
    wr(12'h240, 32'h0);
    wr(12'h248, 32'h0);
    wr(12'h100, 32'h0);
    wr(12'h104, 32'h0);
    wr(12'h200, 32'd5);
    wr(12'h240, 32'h101);
    idle(10);
    chk({31'b0, irq[0]}, 32'h0, "R8 masked irq stays low");
    wr(12'h240, 32'h0);
    rd(12'h244, 32'h1, "R8 status set while masked");
    wr(12'h244, 32'h1);

    // R9 auto-advance across the low-word wrap
    wr(12'h100, 32'hFFFF_FFF8);
    wr(12'h104, 32'h0);
    wr(12'h200, 32'hFFFF_FFFC);
    wr(12'h204, 32'h0);
    wr(12'h208, 32'd8);
    wr(12'h248, 32'h1);
    wr(12'h240, 32'h103);
    idle(14);
    wr(12'h240, 32'h0);
    rd(12'h200, 32'h0000_000C, "R9 target low after two advances");
    rd(12'h204, 32'h0000_0001, "R9 target high after carry");
    rd(12'h100, 32'h0000_0007, "R9 count low after run");
    rd(12'h104, 32'h0000_0001, "R9 count high after run");
    rd(12'h244, 32'h1, "R9 status after periodic match");
    wr(12'h244, 32'h1);

    // R10 general write status
    wr(12'h24C, 32'hFFFF_FFFF);
    rd(12'h24C, 32'h0, "R10 all confirmations cleared");
    wr(12'h200, 32'h0);
    rd(12'h24C, 32'h1, "R10 target low confirmed");
    wr(12'h204, 32'h0);
    wr(12'h208, 32'h0);
    wr(12'h240, 32'h0);
    rd(12'h24C, 32'h0001_0007, "R10 all four confirmed");
    wr(12'h24C, 32'h0001_0001);
    rd(12'h24C, 32'h0000_0006, "R10 selective clear");

    idle(3);
    chk(exp_q.size(), 32'h0, "R5 all reads answered");
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule